// File: doc/BRIEF.md
# Accumulator Register-Reference Execution Unit

This unit holds a 16-bit accumulator and its one-bit extension flag. It carries out the register-reference class of instructions on them. The control sequencer presents the current instruction word and the timing-slot number. When the word has major opcode 111 with the indirect bit clear, and the slot is the register-execute slot (3), the unit decodes the low twelve instruction bits as individual operation selects. These operations clear or complement the accumulator or the flag, rotate the seventeen-bit ring formed by the flag and the accumulator, increment the accumulator, test a skip condition or stop the machine.

The unit also completes the accumulator half of an ADD instruction (major opcode 001) in slot 5. It adds the operand supplied on the data-register input and keeps the carry in the flag. Every action takes effect at the clock edge, and all outputs come from registers. The skip request, the halt request and the sequence-counter clear are single-cycle strobes, and each one appears in the cycle after the instruction was presented.

Top module: `ac_regref_unit`

## Requirements
- R1: While reset is high, and in the first cycle after it, the accumulator and flag read zero and the skip, halt and sequence-clear strobes are low.
- R2: The unit acts only when bits 15..12 of the instruction are 0111 and the slot input equals 3 (register execute), or when bits 14..12 are 001 and the slot equals 5 (ADD execute). In every other cycle, the accumulator and flag keep their values and all three strobes stay low. Any enabled cycle raises the sequence-clear strobe for one cycle.
- R3: Bit 11 sets the accumulator to zero, and bit 10 sets the flag to zero.
- R4: Bit 9 replaces the accumulator with its bitwise inverse, and bit 8 inverts the flag.
- R5: Bit 7 rotates right through the flag: the old flag enters accumulator bit 15, each other bit moves one place down, and old accumulator bit 0 becomes the flag.
- R6: Bit 6 rotates left through the flag: the old flag enters accumulator bit 0, each other bit moves one place up, and old accumulator bit 15 becomes the flag.
- R7: Bit 5 adds one to the accumulator modulo 2^16 and leaves the flag unchanged.
- R8: The skip strobe rises in the next cycle under these conditions: bit 4 with accumulator bit 15 clear, bit 3 with accumulator bit 15 set, bit 2 with the accumulator equal to zero, and bit 1 with the flag clear. Otherwise it stays low. These tests leave the accumulator and flag unchanged.
- R9: Bit 0 raises the halt strobe for one cycle and changes no data.
- R10: In an ADD execute cycle, the flag and accumulator together take the 17-bit sum of the accumulator and the data-register input, with the carry in the flag.
- R11: When more than one of bits 11..0 is set, only the highest set bit acts. When none is set, nothing changes apart from the sequence-clear strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instr | input | 16 | Current instruction word |
| slot | input | 4 | Timing-slot number from the sequence counter |
| dr | input | 16 | Data-register operand for ADD |
| acc | output | 16 | Accumulator |
| ext | output | 1 | Extension (carry) flag |
| pc_inc | output | 1 | Skip strobe: advance the program counter once |
| halt | output | 1 | Halt strobe: clear the run flip-flop |
| seq_clr | output | 1 | Sequence-counter clear strobe |

## Verification
The bench builds the unit with its default widths: a 16-bit accumulator and a 4-bit slot number. At this width the accumulator can be driven to both 0xFFFF and 0x0000, so increment wrap, ADD carry-out and both rotate boundary bits can be exercised directly. A 4-bit slot also allows disabled slots to be presented next to slots 3 and 5. After directed corner cases, a stream of mixed instructions from a linear-feedback sequence is applied. This stream includes multi-bit selects and disabled slots, and every cycle is compared against a behavioural model.

// File: rtl/ac_regref_pkg.sv
package ac_regref_pkg;
  localparam int INSTR_W = 16;
  localparam int OP_N    = 12;

  localparam logic [2:0] OPC_REGREF = 3'b111;
  localparam logic [2:0] OPC_ADD    = 3'b001;

  // positions of the operation-select bits in the instruction word
  localparam int OP_CLR_AC = 11;
  localparam int OP_CLR_E  = 10;
  localparam int OP_INV_AC = 9;
  localparam int OP_INV_E  = 8;
  localparam int OP_ROR    = 7;
  localparam int OP_ROL    = 6;
  localparam int OP_INC    = 5;
  localparam int OP_SK_POS = 4;
  localparam int OP_SK_NEG = 3;
  localparam int OP_SK_ZAC = 2;
  localparam int OP_SK_ZE  = 1;
  localparam int OP_STOP   = 0;

  typedef struct packed {
    logic            ind;
    logic [2:0]      opc;
    logic [OP_N-1:0] ops;
  } instr_t;
endpackage

// File: rtl/ac_op_select.sv
module ac_op_select #(
  parameter int OP_N = 12
) (
  input  logic [OP_N-1:0] ops,
  output logic [OP_N-1:0] sel
);
  // fixed priority: highest set bit wins, result is one-hot or zero
  for (genvar i = 0; i < OP_N; i++) begin : g_pri
    if (i == OP_N - 1) begin : g_top
      assign sel[i] = ops[i];
    end else begin : g_low
      assign sel[i] = ops[i] & ~(|ops[OP_N-1:i+1]);
    end
  end
endmodule

// File: rtl/ac_datapath.sv
module ac_datapath
  import ac_regref_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic [DATA_W-1:0] acc,
  input  logic              ext,
  input  logic [OP_N-1:0]   sel,
  input  logic [DATA_W-1:0] dr,
  input  logic              rr_en,
  input  logic              add_en,
  output logic [DATA_W-1:0] nxt_acc,
  output logic              nxt_ext
);
  localparam int SUM_W = DATA_W + 1;

  logic [SUM_W-1:0] sum;
  assign sum = {1'b0, acc} + {1'b0, dr};

  always_comb begin
    nxt_acc = acc;
    nxt_ext = ext;
    if (add_en) begin
      {nxt_ext, nxt_acc} = sum;
    end else if (rr_en) begin
      if (sel[OP_CLR_AC]) nxt_acc = '0;
      if (sel[OP_CLR_E])  nxt_ext = 1'b0;
      if (sel[OP_INV_AC]) nxt_acc = ~acc;
      if (sel[OP_INV_E])  nxt_ext = ~ext;
      if (sel[OP_ROR]) begin
        nxt_acc = {ext, acc[DATA_W-1:1]};
        nxt_ext = acc[0];
      end
      if (sel[OP_ROL]) begin
        nxt_acc = {acc[DATA_W-2:0], ext};
        nxt_ext = acc[DATA_W-1];
      end
      if (sel[OP_INC]) nxt_acc = acc + 1'b1;
    end
  end
endmodule

// File: rtl/ac_skip_eval.sv
module ac_skip_eval
  import ac_regref_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic [DATA_W-1:0] acc,
  input  logic              ext,
  input  logic [OP_N-1:0]   sel,
  output logic              skip
);
  logic sign, zac;
  assign sign = acc[DATA_W-1];
  assign zac  = (acc == '0);

  assign skip = (sel[OP_SK_POS] & ~sign) |
                (sel[OP_SK_NEG] &  sign) |
                (sel[OP_SK_ZAC] &  zac)  |
                (sel[OP_SK_ZE]  & ~ext);
endmodule

// File: rtl/ac_regref_unit.sv
module ac_regref_unit
  import ac_regref_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int SLOT_W   = 4,
  parameter int RR_SLOT  = 3,
  parameter int ADD_SLOT = 5
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [INSTR_W-1:0]   instr,
  input  logic [SLOT_W-1:0]    slot,
  input  logic [DATA_W-1:0]    dr,
  output logic [DATA_W-1:0]    acc,
  output logic                 ext,
  output logic                 pc_inc,
  output logic                 halt,
  output logic                 seq_clr
);
  instr_t            iw;
  logic              rr_en, add_en;
  logic [OP_N-1:0]   sel;
  logic [DATA_W-1:0] nxt_acc;
  logic              nxt_ext, skip;

  assign iw     = instr_t'(instr);
  assign rr_en  = !iw.ind && (iw.opc == OPC_REGREF) && (slot == SLOT_W'(RR_SLOT));
  assign add_en = (iw.opc == OPC_ADD) && (slot == SLOT_W'(ADD_SLOT));

  ac_op_select #(.OP_N(OP_N)) u_sel (
    .ops (iw.ops),
    .sel (sel)
  );

  ac_datapath #(.DATA_W(DATA_W)) u_dp (
    .acc     (acc),
    .ext     (ext),
    .sel     (sel),
    .dr      (dr),
    .rr_en   (rr_en),
    .add_en  (add_en),
    .nxt_acc (nxt_acc),
    .nxt_ext (nxt_ext)
  );

  ac_skip_eval #(.DATA_W(DATA_W)) u_skip (
    .acc  (acc),
    .ext  (ext),
    .sel  (sel),
    .skip (skip)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      acc     <= '0;
      ext     <= 1'b0;
      pc_inc  <= 1'b0;
      halt    <= 1'b0;
      seq_clr <= 1'b0;
    end else begin
      acc     <= nxt_acc;
      ext     <= nxt_ext;
      pc_inc  <= rr_en & skip;
      halt    <= rr_en & sel[OP_STOP];
      seq_clr <= rr_en | add_en;
    end
  end
endmodule

// File: rtl/ac_regref_checks.sv
module ac_regref_checks #(
  parameter int DATA_W   = 16,
  parameter int SLOT_W   = 4,
  parameter int RR_SLOT  = 3,
  parameter int ADD_SLOT = 5
) (
  input logic              clk,
  input logic              rst,
  input logic [15:0]       instr,
  input logic [SLOT_W-1:0] slot,
  input logic [DATA_W-1:0] dr,
  input logic [DATA_W-1:0] acc,
  input logic              ext,
  input logic              pc_inc,
  input logic              halt,
  input logic              seq_clr
);
  logic rr_go, add_go;
  assign rr_go  = (instr[15:12] == 4'b0111) && (slot == SLOT_W'(RR_SLOT));
  assign add_go = (instr[14:12] == 3'b001) && (slot == SLOT_W'(ADD_SLOT));

  assert_idle_hold_R2: assert property (@(posedge clk) disable iff (rst)
    (!rr_go && !add_go) |=> ($stable(acc) && $stable(ext) && !pc_inc && !halt && !seq_clr));

  assert_seq_clear_R2: assert property (@(posedge clk) disable iff (rst)
    (rr_go || add_go) |=> seq_clr);

  assert_clear_ac_R3: assert property (@(posedge clk) disable iff (rst)
    (rr_go && instr[11]) |=> (acc == '0));

  assert_invert_ac_R4: assert property (@(posedge clk) disable iff (rst)
    (rr_go && instr[11:9] == 3'b001) |=> (acc == ~$past(acc)));

  assert_skip_origin_R8: assert property (@(posedge clk) disable iff (rst)
    pc_inc |-> $past(rr_go));

  assert_halt_origin_R9: assert property (@(posedge clk) disable iff (rst)
    halt |-> ($past(rr_go) && $past(instr[11:0]) == 12'h001));

  assert_add_sum_R10: assert property (@(posedge clk) disable iff (rst)
    add_go |=> ({ext, acc} == ({1'b0, $past(acc)} + {1'b0, $past(dr)})));

  assert_one_action_R11: assert property (@(posedge clk) disable iff (rst)
    $onehot0({pc_inc, halt}));
endmodule

bind ac_regref_unit ac_regref_checks #(
  .DATA_W(DATA_W), .SLOT_W(SLOT_W), .RR_SLOT(RR_SLOT), .ADD_SLOT(ADD_SLOT)
) u_checks (
  .clk(clk), .rst(rst), .instr(instr), .slot(slot), .dr(dr),
  .acc(acc), .ext(ext), .pc_inc(pc_inc), .halt(halt), .seq_clr(seq_clr)
);

// File: tb/ac_regref_unit_test.sv
`timescale 1ns/1ps
module ac_regref_unit_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] instr = 16'h0000;
  logic [3:0]  slot = 4'd0;
  logic [15:0] dr = 16'h0000;
  logic [15:0] acc;
  logic        ext, pc_inc, halt, seq_clr;

  int n_chk = 0;
  int n_bad = 0;
  logic [15:0] m_acc = 16'h0;
  logic        m_e = 1'b0, m_pc = 1'b0, m_halt = 1'b0, m_sc = 1'b0;

  always #10 clk = ~clk;

  ac_regref_unit uut (
    .clk(clk), .rst(rst), .instr(instr), .slot(slot), .dr(dr),
    .acc(acc), .ext(ext), .pc_inc(pc_inc), .halt(halt), .seq_clr(seq_clr)
  );

  task automatic compare(input string tag);
    n_chk++;
    if ({acc, ext, pc_inc, halt, seq_clr} !== {m_acc, m_e, m_pc, m_halt, m_sc}) begin
      n_bad++;
      $display("FAIL %s: acc=%h e=%b pc=%b halt=%b sc=%b expected acc=%h e=%b pc=%b halt=%b sc=%b",
               tag, acc, ext, pc_inc, halt, seq_clr, m_acc, m_e, m_pc, m_halt, m_sc);
    end
  endtask

  task automatic step(input logic [15:0] ins, input logic [3:0] sl,
                      input logic [15:0] d, input string tag);
    int top;
    int sum;
    instr = ins; slot = sl; dr = d;
    @(posedge clk);
    m_pc = 1'b0; m_halt = 1'b0; m_sc = 1'b0;
    if (ins[15:12] == 4'h7 && sl == 4'd3) begin
      m_sc = 1'b1;
      top = -1;
      for (int b = 11; b >= 0; b--) if (ins[b] && top < 0) top = b;
      case (top)
        11: m_acc = 16'h0;
        10: m_e = 1'b0;
        9:  m_acc = ~m_acc;
        8:  m_e = ~m_e;
        7:  begin logic lo; lo = m_acc[0]; m_acc = {m_e, m_acc[15:1]}; m_e = lo; end
        6:  begin logic hi; hi = m_acc[15]; m_acc = {m_acc[14:0], m_e}; m_e = hi; end
        5:  m_acc = m_acc + 16'h1;
        4:  m_pc = (m_acc[15] == 1'b0);
        3:  m_pc = (m_acc[15] == 1'b1);
        2:  m_pc = (m_acc == 16'h0);
        1:  m_pc = (m_e == 1'b0);
        0:  m_halt = 1'b1;
        default: ;
      endcase
    end else if (ins[14:12] == 3'b001 && sl == 4'd5) begin
      m_sc = 1'b1;
      sum = int'(m_acc) + int'(d);
      m_acc = sum[15:0];
      m_e = sum[16];
    end
    @(negedge clk);
    compare(tag);
  endtask

  initial begin
    #(200000 * 20);
    n_chk++; n_bad++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    logic [15:0] lf;
    repeat (3) @(posedge clk);
    @(negedge clk);
    compare("R1 during reset");
    rst = 1'b0;
    @(posedge clk); @(negedge clk);
    compare("R1 after reset");

    step(16'h1000, 4'd5, 16'h8001, "R10 add from zero");
    step(16'h9000, 4'd5, 16'h8000, "R10 add carry out, indirect form");
    step(16'h7040, 4'd3, 16'h0,    "R6 rotate left");
    step(16'h7080, 4'd3, 16'h0,    "R5 rotate right");
    step(16'h7080, 4'd3, 16'h0,    "R5 rotate right again");
    step(16'h7200, 4'd3, 16'h0,    "R4 invert acc");
    step(16'h7100, 4'd3, 16'h0,    "R4 invert flag");
    step(16'h7010, 4'd3, 16'h0,    "R8 skip positive");
    step(16'h7008, 4'd3, 16'h0,    "R8 skip negative");
    step(16'h7002, 4'd3, 16'h0,    "R8 skip flag zero");
    step(16'h7800, 4'd3, 16'h0,    "R3 clear acc");
    step(16'h7004, 4'd3, 16'h0,    "R8 skip acc zero");
    step(16'h7010, 4'd3, 16'h0,    "R8 skip positive at zero");
    step(16'h7008, 4'd3, 16'h0,    "R8 no skip negative at zero");
    step(16'h7200, 4'd3, 16'h0,    "R4 invert to all ones");
    step(16'h7020, 4'd3, 16'h0,    "R7 increment wraps");
    step(16'h7020, 4'd3, 16'h0,    "R7 increment");
    step(16'h7004, 4'd3, 16'h0,    "R8 no skip acc nonzero");
    step(16'h7100, 4'd3, 16'h0,    "R4 set flag");
    step(16'h7002, 4'd3, 16'h0,    "R8 no skip flag set");
    step(16'h7400, 4'd3, 16'h0,    "R3 clear flag");
    step(16'h7001, 4'd3, 16'h0,    "R9 halt");
    step(16'h7880, 4'd3, 16'h0,    "R11 clear beats rotate");
    step(16'h7021, 4'd3, 16'h0,    "R11 increment beats halt");
    step(16'h7000, 4'd3, 16'h0,    "R11 no select bit");
    step(16'h7800, 4'd2, 16'h0,    "R2 wrong slot");
    step(16'hF800, 4'd3, 16'h0,    "R2 indirect bit set");
    step(16'h3800, 4'd3, 16'h0,    "R2 other opcode");
    step(16'h1000, 4'd4, 16'h1234, "R2 add wrong slot");

    lf = 16'hACE1;
    for (int k = 0; k < 400; k++) begin
      logic [15:0] ins;
      logic [3:0]  sl;
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      case (lf[1:0])
        2'd0: ins = {lf[15], 3'b001, lf[11:0]};
        2'd1: ins = {4'h7, lf[11:0] & lf[7:0] << 4};
        default: ins = {4'h7, 12'h001 << (lf[7:4] % 12)};
      endcase
      sl = lf[2] ? 4'(lf[3] ? 5 : 3) : lf[15:12];
      step(ins, sl, {lf[7:0], lf[15:8]}, "R11 mixed stream");
    end

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule